// File: doc/BRIEF.md
# Multi-Width Write Transmit Byte Queue

This block is the transmit queue of a serial-style peripheral. A host on a simple register bus pushes one, two or four bytes per write, choosing the count by the register address it writes. The bytes land in a byte-wide circular queue. A downstream serializer removes them one at a time over a valid/ready handshake. A read-only register reports how many bytes are queued.

A status register holds two sticky flags. The first is the ready flag, which also drives the `irq` pin. It is set only on the cycle in which the occupancy falls from exactly one byte to zero. The second is an overflow flag. It is set when a write is refused because the queue lacks room for all of its bytes. Writing a 1 to a flag's bit clears that flag. A multi-byte write is accepted as a whole or refused as a whole, so the serializer never sees part of it.

Top module: `txq_multiwidth`

## Requirements
- R1: After reset the depth is 0, `tx_valid` is 0, `irq` is 0 and both status flags read 0.
- R2: A bus write to address 0 queues one byte, `bus_wdata[7:0]`.
- R3: A write to address 1 queues `bus_wdata[7:0]` then `bus_wdata[15:8]`. A write to address 2 queues all four bytes, least significant byte first.
- R4: A bus read of address 3 returns the depth in `bus_rdata[4:0]`, with the upper bits zero. The value appears on `bus_rdata` one cycle after `bus_rd`.
- R5: `tx_valid` is high whenever the queue is non-empty, and `tx_data` shows the oldest byte. A byte is removed in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low the head byte holds steady.
- R6: A write whose byte count exceeds the free slots is dropped whole, and status bit 1 (overflow) is set and stays set. Free slots are counted at the start of the cycle, so a drain in the same cycle does not make room.
- R7: An accepted write changes the depth by its full byte count in a single cycle, and never by only part of it.
- R8: Status bit 0 (ready flag, also the `irq` pin) is set only when the depth goes from 1 to 0 through a drain. Draining attempts on an empty queue, and reset, do not set it. The flag stays set until it is cleared.
- R9: If a push and a drain happen in the same cycle while the depth is 1, the depth never reaches zero and no ready flag is raised.
- R10: A write to address 4 clears status bit 0 if `bus_wdata[0]` is 1, and clears bit 1 if `bus_wdata[1]` is 1. A set event in the same cycle as a clear wins, and the flag stays set. A status read is also at address 4.
- R11: The queue holds 16 bytes. Sixteen single-byte writes are all accepted, and a seventeenth is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address (0 push1, 1 push2, 2 push4, 3 depth, 4 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Head byte toward the serializer |
| tx_valid | output | 1 | Queue non-empty |
| tx_ready | input | 1 | Serializer accepts the head byte |
| irq | output | 1 | Level output of the sticky ready flag |

## Verification
The hardest cases to reach are the ones that depend on two actions landing in the same clock edge. The first is a push coinciding with the last byte's drain. The second is a clear coinciding with the 1-to-0 drain. The third is a write refused at a full queue while a byte leaves. The bench drives the bus strobe and `tx_ready` together on the same falling edge so that both act on one rising edge. It also sweeps every starting fill from 0 to 16 against each of the three write widths, which reaches every fit and overflow boundary.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    REG_PUSH1 = 3'd0,
    REG_PUSH2 = 3'd1,
    REG_PUSH4 = 3'd2,
    REG_DEPTH = 3'd3,
    REG_STAT  = 3'd4
  } txq_reg_e;

  localparam int STAT_RDY_BIT = 0;
  localparam int STAT_OVF_BIT = 1;
endpackage

// File: rtl/txq_regdec.sv
module txq_regdec
  import txq_pkg::*;
#(
  parameter int NW = 3
) (
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [NW-1:0] push_n,
  output logic          clr_rdy,
  output logic          clr_ovf
);
  always_comb begin
    push_n  = '0;
    clr_rdy = 1'b0;
    clr_ovf = 1'b0;
    if (bus_wr) begin
      case (txq_reg_e'(bus_addr))
        REG_PUSH1: push_n = NW'(1);
        REG_PUSH2: push_n = NW'(2);
        REG_PUSH4: push_n = NW'(4);
        REG_STAT: begin
          clr_rdy = bus_wdata[STAT_RDY_BIT];
          clr_ovf = bus_wdata[STAT_OVF_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txq_bytefifo.sv
module txq_bytefifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NW    = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NW-1:0]      push_n,
  input  logic [LANES*8-1:0] push_bytes,
  input  logic               pop,
  output logic [CNT_W-1:0]   count,
  output logic [7:0]         head,
  output logic               refuse_evt,
  output logic               empty_evt
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] free_slots;
  logic             fits, accept, do_pop;

  // Room is judged on the occupancy at the start of the cycle.
  assign free_slots = CNT_W'(DEPTH) - count;
  assign fits       = CNT_W'(push_n) <= free_slots;
  assign accept     = (push_n != '0) && fits;
  assign refuse_evt = (push_n != '0) && !fits;
  assign do_pop     = pop && (count != '0);
  assign empty_evt  = do_pop && (count == CNT_W'(1)) && !accept;
  assign head       = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int l = 0; l < LANES; l++) begin
        if (NW'(l) < push_n)
          mem[PTR_W'(wr_ptr + PTR_W'(l))] <= push_bytes[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= PTR_W'(wr_ptr + PTR_W'(push_n));
      if (do_pop) rd_ptr <= PTR_W'(rd_ptr + PTR_W'(1));
      count <= count + (accept ? CNT_W'(push_n) : CNT_W'(0)) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/txq_sticky.sv
module txq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/txq_multiwidth.sv
module txq_multiwidth
  import txq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int LANES = 4;
  localparam int NW    = $clog2(LANES + 1);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NW-1:0]    push_n;
  logic             clr_rdy, clr_ovf;
  logic [CNT_W-1:0] fifo_count;
  logic             refuse_evt, empty_evt;
  logic             rdy_flag, ovf_flag;

  txq_regdec #(.NW(NW)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .push_n   (push_n),
    .clr_rdy  (clr_rdy),
    .clr_ovf  (clr_ovf)
  );

  txq_bytefifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_n),
    .push_bytes(bus_wdata),
    .pop       (tx_ready),
    .count     (fifo_count),
    .head      (tx_data),
    .refuse_evt(refuse_evt),
    .empty_evt (empty_evt)
  );

  txq_sticky u_rdy (
    .clk(clk), .rst(rst), .set_evt(empty_evt), .clr(clr_rdy), .flag(rdy_flag)
  );

  txq_sticky u_ovf (
    .clk(clk), .rst(rst), .set_evt(refuse_evt), .clr(clr_ovf), .flag(ovf_flag)
  );

  assign tx_valid = fifo_count != '0;
  assign irq      = rdy_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (txq_reg_e'(bus_addr))
        REG_DEPTH: bus_rdata <= 32'(fifo_count);
        REG_STAT:  bus_rdata <= {30'b0, ovf_flag, rdy_flag};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] depth,
  input logic             irq,
  input logic             ovf,
  input logic             clr_rdy,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !ovf && !tx_valid));

  p_head_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_refuse_no_grow_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> (depth <= $past(depth)));

  p_irq_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(depth) == CNT_W'(1) && depth == '0));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_rdy) |=> irq);

  p_depth_bound_r11: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));
endmodule

bind txq_multiwidth txq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .depth   (fifo_count),
  .irq     (irq),
  .ovf     (ovf_flag),
  .clr_rdy (clr_rdy),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .tx_data (tx_data)
);

// File: tb/txq_multiwidth_tb.sv
`timescale 1ns/1ps
module txq_multiwidth_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 1'b0, irq;

  int checks = 0, errors = 0;
  logic [7:0] mq [0:63];
  int head = 0, tail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txq_multiwidth u_dut (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Model push: returns 1 if accepted
  function automatic bit mpush(int n, logic [31:0] d);
    if (n > 16 - (tail - head)) return 0;
    for (int k = 0; k < n; k++) begin
      mq[tail % 64] = d[k*8 +: 8];
      tail++;
    end
    return 1;
  endfunction

  task automatic drain_all(string req);
    @(negedge clk);
    tx_ready = 1'b1;
    while (head != tail) begin
      chk(tx_valid === 1'b1, "R5", 32'(tx_valid), 1);
      chk(tx_data === mq[head % 64], req, 32'(tx_data), 32'(mq[head % 64]));
      head++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk(tx_valid === 1'b0, "R5", 32'(tx_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(tx_valid === 1'b0 && irq === 1'b0, "R1", {tx_valid, irq}, 0);
    bread(3'd3, rd); chk(rd === 0, "R1 depth", rd, 0);
    bread(3'd4, rd); chk(rd === 0, "R1 status", rd, 0);

    // R8: draining an empty queue does not raise the flag
    @(negedge clk); tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    tx_ready = 1'b0;
    chk(irq === 1'b0, "R8 empty drain", 32'(irq), 0);

    // Sweep every start fill against every width (R2, R3, R4, R6, R7, R8, R11)
    for (int f = 0; f <= 16; f++) begin
      for (int w = 0; w < 3; w++) begin
        int n;
        logic [31:0] pat;
        n = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        for (int k = 0; k < f; k++) begin
          logic [31:0] b;
          b = 32'((f * 37 + k * 11 + w * 5) & 8'hFF);
          ok = mpush(1, b);
          bwrite(3'd0, b);
        end
        bread(3'd3, rd); chk(rd === 32'(f), "R11 fill depth R4", rd, 32'(f));
        pat = 32'hA0B0C0D0 ^ (32'(f) << 8) ^ 32'(w);
        ok = mpush(n, pat);
        bwrite(3'(w), pat);
        bread(3'd3, rd);
        chk(rd === 32'(tail - head), "R7 depth after wide write", rd, 32'(tail - head));
        bread(3'd4, rd);
        chk(rd[1] === !ok, "R6 overflow flag", 32'(rd[1]), 32'(!ok));
        drain_all("R3 byte order");
        chk(irq === 1'b1, "R8 drain to empty", 32'(irq), 1);
        bwrite(3'd4, 32'h3);
        bread(3'd4, rd); chk(rd === 0, "R10 clear both", rd, 0);
      end
    end

    // R9: push and drain together at depth 1
    ok = mpush(1, 32'h5A); bwrite(3'd0, 32'h5A);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h77; tx_ready = 1'b1;
    head++; ok = mpush(1, 32'h77);
    @(negedge clk);
    bus_wr = 1'b0; tx_ready = 1'b0;
    chk(irq === 1'b0, "R9 no flag on push+drain", 32'(irq), 0);
    chk(tx_data === 8'h77, "R9 new head", 32'(tx_data), 32'h77);

    // R10: set wins over same-cycle clear. First raise the flag.
    drain_all("R5 drain");
    chk(irq === 1'b1, "R8 raised", 32'(irq), 1);
    ok = mpush(1, 32'h33); bwrite(3'd0, 32'h33);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h1; tx_ready = 1'b1;
    head++;
    @(negedge clk);
    bus_wr = 1'b0; tx_ready = 1'b0;
    chk(irq === 1'b1, "R10 set beats clear", 32'(irq), 1);
    bwrite(3'd4, 32'h1);
    chk(irq === 1'b0, "R10 clear alone", 32'(irq), 0);

    // R6: full queue, a drain in the same cycle does not make room
    for (int k = 0; k < 16; k++) begin
      ok = mpush(1, 32'(k + 8'h40)); bwrite(3'd0, 32'(k + 8'h40));
    end
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'hEE; tx_ready = 1'b1;
    head++;
    @(negedge clk);
    bus_wr = 1'b0; tx_ready = 1'b0;
    bread(3'd3, rd); chk(rd === 15, "R6 refused at full", rd, 15);
    bread(3'd4, rd); chk(rd[1] === 1'b1, "R6 sticky overflow", 32'(rd[1]), 1);
    bwrite(3'd4, 32'h2);
    bread(3'd4, rd); chk(rd[1] === 1'b0, "R10 overflow clear", 32'(rd[1]), 0);
    drain_all("R5 tail order");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule